// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces word addresses for a synchronous burst memory. An external address is captured on a rising clock edge when one of two active-low address strobes is asserted. One strobe serves a processor. The other serves a memory controller. After the capture, an active-low advance input steps the low address bits through a four-beat burst, so a 2-1-1-1 access gets one beat per clock after the first.

A static order input chooses the beat sequence:

- Linear order counts the low bits upward.
- Interleaved order XORs the low bits with the beat count.

The order input is not clocked, so a change reaches the address output without a clock edge. The upper address bits hold for the whole burst. The chip-select state sampled at the load is kept and brought out as `sel`.

The processor strobe is qualified by the chip enable. The controller strobe is not.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low and after reset, `addr_out` is 0, `beat` is 0 and `sel` is 0.
- R2: With `ads_proc_n` = 0 and `ce_n` = 0 at an edge, `addr_in` is loaded. After that edge, `addr_out` equals the loaded address, `beat` is 0 and `sel` is 1.
- R3: With `ads_proc_n` = 0, `ce_n` = 1, `ads_ctrl_n` = 1 and `adv_n` = 1 at an edge, the strobe is ignored. `addr_out`, `beat` and `sel` are unchanged after the edge.
- R4: With `ads_ctrl_n` = 0 at an edge, `addr_in` is loaded whatever `ce_n` is. `beat` becomes 0 and `sel` becomes the inverse of the sampled `ce_n`.
- R5: With no load and `adv_n` = 0 at an edge, `beat` increments by one modulo 4.
- R6: With no load and `adv_n` = 1 at an edge, `beat` and `addr_out` hold.
- R7: A load at an edge takes priority over `adv_n` = 0 in the same cycle. `beat` becomes 0 and the new address appears.
- R8: With `order_sel` = 0 (linear), `addr_out[1:0]` = (loaded low bits + `beat`) mod 4. The upper bits `addr_out[AW-1:2]` never change without a load.
- R9: With `order_sel` = 1 (interleaved), `addr_out[1:0]` = loaded low bits XOR `beat`.
- R10: After four advances the address returns to its start value, and it keeps cycling while advance stays asserted.
- R11: A change of `order_sel` alters `addr_out` at once, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ads_proc_n | input | 1 | Processor address strobe, active low, qualified by `ce_n` |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved (unclocked) |
| addr_in | input | AW | External start address |
| addr_out | output | AW | Current burst address |
| beat | output | 2 | Beat index within the burst |
| sel | output | 1 | Chip-select state captured at the last load |

## Verification
The burst is run from each of the four starting low-bit values in both orders, with seven advances each time. Starting values 1 and 3 are where the sum and the XOR sequences diverge, so a swapped or mixed-up order is exposed. Running past the fourth beat also exposes a missing or wrong wrap. Separate patterns pair each strobe with each chip-enable level, which distinguishes qualified from unqualified loads. A load made together with advance shows whether load wins over stepping. Flipping the order input between edges confirms that the mapping is not registered.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_load_ctl.sv
module bseq_load_ctl (
    input  logic ads_proc_n,
    input  logic ads_ctrl_n,
    input  logic ce_n,
    input  logic adv_n,
    output logic load,
    output logic step
);
    logic proc_hit;
    logic ctrl_hit;

    always_comb begin
        // processor strobe only counts while the chip is enabled
        proc_hit = !ads_proc_n && !ce_n;
        ctrl_hit = !ads_ctrl_n;
        load     = proc_hit || ctrl_hit;
        // a load always wins over stepping
        step     = !load && !adv_n;
    end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    output logic [CW-1:0] cnt
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.cnt = '0;
        end else if (step) begin
            ctr_d.cnt = ctr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt = ctr_q.cnt;

    // R7
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == '0));

    // R5
    step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> (cnt == $past(cnt) + CW'(1)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cnt));
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
    import bseq_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic [CW-1:0] start_lo,
    input  logic [CW-1:0] cnt,
    input  logic          order_sel,
    output logic [CW-1:0] cur_lo
);
    order_e ord;

    always_comb begin
        ord = order_e'(order_sel);
        if (ord == ORD_INTERLEAVE) begin
            cur_lo = start_lo ^ cnt;
        end else begin
            cur_lo = start_lo + cnt;
        end
    end

    // R9
    always_comb begin
        if (order_sel) begin
            ilv_self_inverse_chk: assert ((cur_lo ^ cnt) == start_lo);
        end
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int AW = 20,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ads_proc_n,
    input  logic          ads_ctrl_n,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          order_sel,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic [BW-1:0] beat,
    output logic          sel
);
    localparam int HW = AW - BW;

    typedef struct packed {
        logic [AW-1:0] base;
        logic          sel;
    } cap_t;

    cap_t cap_d, cap_q;

    logic          load;
    logic          step;
    logic [BW-1:0] cnt;
    logic [BW-1:0] cur_lo;

    bseq_load_ctl u_ctl (
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .ce_n       (ce_n),
        .adv_n      (adv_n),
        .load       (load),
        .step       (step)
    );

    bseq_beat_ctr #(.CW(BW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .cnt   (cnt)
    );

    bseq_order_map #(.CW(BW)) u_map (
        .start_lo  (cap_q.base[BW-1:0]),
        .cnt       (cnt),
        .order_sel (order_sel),
        .cur_lo    (cur_lo)
    );

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.base = addr_in;
            cap_d.sel  = !ce_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_out = {cap_q.base[AW-1:BW], cur_lo};
    assign beat     = cnt;
    assign sel      = cap_q.sel;

    // R3
    proc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && ce_n && ads_ctrl_n) |=> ($stable(sel) && $stable(addr_out[AW-1:BW])));

    // R4
    ctrl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_ctrl_n |=> (sel == !$past(ce_n)));

    // R8
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[AW-1:BW]));

    // R2
    proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && !ce_n) |=> (sel && addr_out[AW-1:BW] == $past(addr_in[AW-1:BW])));

    initial begin
        // HW must leave room for upper bits
        width_ok_chk: assert (HW > 0);
    end
endmodule

// File: tb/sim_burst_seq.sv
module sim_burst_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ads_proc_n = 1'b1;
    logic          ads_ctrl_n = 1'b1;
    logic          ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;
    logic          sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    burst_seq #(.AW(AW), .BW(2)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .ce_n       (ce_n),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .addr_in    (addr_in),
        .addr_out   (addr_out),
        .beat       (beat),
        .sel        (sel)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ads_proc_n = 1'b1;
        ads_ctrl_n = 1'b1;
        adv_n      = 1'b1;
    endtask

    function automatic logic [1:0] exp_lo(input logic [1:0] b, input logic [1:0] k, input logic ilv);
        return ilv ? (b ^ k) : (b + k);
    endfunction

    task automatic ctrl_load(input logic [AW-1:0] a, input logic cen);
        ads_ctrl_n = 1'b0;
        ce_n       = cen;
        addr_in    = a;
        tick();
        idle();
    endtask

    task automatic t_reset();
        tick();
        chk("R1 addr", 32'(addr_out), 0);
        chk("R1 beat", 32'(beat), 0);
        chk("R1 sel", 32'(sel), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 addr after release", 32'(addr_out), 0);
    endtask

    task automatic t_proc_load();
        ads_proc_n = 1'b0;
        ce_n       = 1'b0;
        addr_in    = 20'h3A5C6;
        tick();
        idle();
        chk("R2 addr", 32'(addr_out), 32'h3A5C6);
        chk("R2 beat", 32'(beat), 0);
        chk("R2 sel", 32'(sel), 1);
    endtask

    task automatic t_proc_ignored();
        ctrl_load(20'h12340, 1'b0);
        adv_n = 1'b0;
        tick();
        idle();
        ads_proc_n = 1'b0;
        ce_n       = 1'b1;
        addr_in    = 20'h77773;
        tick();
        idle();
        chk("R3 addr", 32'(addr_out), 32'h12341);
        chk("R3 beat", 32'(beat), 1);
        chk("R3 sel", 32'(sel), 1);
    endtask

    task automatic t_ctrl_load();
        ctrl_load(20'h0F0F2, 1'b1);
        chk("R4 addr ce off", 32'(addr_out), 32'h0F0F2);
        chk("R4 sel ce off", 32'(sel), 0);
        chk("R4 beat", 32'(beat), 0);
        ctrl_load(20'h0A0A1, 1'b0);
        chk("R4 addr ce on", 32'(addr_out), 32'h0A0A1);
        chk("R4 sel ce on", 32'(sel), 1);
    endtask

    task automatic t_burst(input logic ilv);
        order_sel = ilv;
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] base;
            base = {18'h2B3C5, 2'(s)};
            ctrl_load(base, 1'b0);
            for (int k = 1; k <= 7; k++) begin
                adv_n = 1'b0;
                tick();
                chk("R5 beat", 32'(beat), 32'(k % 4));
                chk(ilv ? "R9 low bits" : "R8 low bits", 32'(addr_out[1:0]),
                    32'(exp_lo(2'(s), 2'(k % 4), ilv)));
                chk("R8 upper", 32'(addr_out[AW-1:2]), 32'h2B3C5);
                if (k == 4) chk("R10 wrap", 32'(addr_out), 32'(base));
            end
            idle();
        end
        order_sel = 1'b0;
    endtask

    task automatic t_hold();
        ctrl_load(20'h55552, 1'b0);
        adv_n = 1'b0;
        tick();
        tick();
        adv_n = 1'b1;
        tick();
        tick();
        chk("R6 beat", 32'(beat), 2);
        chk("R6 addr", 32'(addr_out), 32'h55550);
    endtask

    task automatic t_priority();
        ctrl_load(20'h11110, 1'b0);
        adv_n = 1'b0;
        tick();
        tick();
        ads_proc_n = 1'b0;
        ads_ctrl_n = 1'b0;
        ce_n       = 1'b0;
        addr_in    = 20'h9ABC3;
        tick();
        idle();
        chk("R7 beat", 32'(beat), 0);
        chk("R7 addr", 32'(addr_out), 32'h9ABC3);
    endtask

    task automatic t_mode_async();
        order_sel = 1'b0;
        ctrl_load(20'h44441, 1'b0);
        adv_n = 1'b0;
        tick();
        idle();
        chk("R11 linear", 32'(addr_out), 32'h44442);
        order_sel = 1'b1;
        #1;
        chk("R11 interleaved no edge", 32'(addr_out), 32'h44440);
        order_sel = 1'b0;
        #1;
        chk("R11 back to linear", 32'(addr_out), 32'h44442);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2;
        t_reset();
        t_proc_load();
        t_proc_ignored();
        t_ctrl_load();
        t_burst(1'b0);
        t_burst(1'b1);
        t_hold();
        t_priority();
        t_mode_async();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule